// File: doc/BRIEF.md
# CAN Overload Frame Trigger

This block decides when a CAN node has to put an overload frame on the bus, and then drives that frame one bit at a time. It watches the sampled bus level on each bit strobe. A frame parser outside the block supplies markers that say where the current bit lies: inside the intermission and at which index, on the closing bit of end-of-frame, or on the closing bit of an error delimiter. From these markers and the bus level the block recognises the conditions that force a reactive overload.

The block can also add a deliberate delay after a received message has been stored. This is a requested overload, and it runs only when the enable input is set. Reactive overloads run whether the enable is set or not.

While an overload frame is on the bus, the block raises a hold signal so that the fault-confinement counters ignore it. It has no other effect on those counters. Bus levels are active-low: 0 is dominant and 1 is recessive.

Top module: `can_ovld_trigger`

## Requirements
- R1: After reset the block is idle: `tx_bit` is 1 (recessive), and `busy` and `cnt_hold` are 0.
- R2: When idle, a strobed bit with `rx_bit`=0 and `in_ifs`=1 starts an overload flag if `ifs_pos` is 0 or 1. The flag begins on the next bit. The same bit at `ifs_pos`=2 starts nothing.
- R3: When idle, a strobed dominant bit with `eof_last`=1 starts an overload if `is_tx`=0 (receiver). It starts nothing if `is_tx`=1 (transmitter).
- R4: When idle, a strobed dominant bit with `err_dlm_last`=1 starts an overload in either role. A recessive bit there starts nothing.
- R5: A dominant bit sampled on the eighth (last) bit of the block's own overload delimiter starts a new overload flag on the next bit.
- R6: A `msg_stored` pulse while `req_en`=1 arms a requested overload. It is sent starting on the bit after the next `eof_last` strobe, which is intermission bit 0. A pulse while `req_en`=0 arms nothing.
- R7: An armed request that arrives during an overload is served on the bit after that overload's delimiter ends. At most two requested overloads are sent between two `sof_seen` pulses, and a third request is dropped. A `sof_seen` pulse resets the limit.
- R8: An overload frame is 6 bits with `tx_bit`=0 followed by 8 bits with `tx_bit`=1. `tx_bit` changes only on a bit strobe.
- R9: `cnt_hold` and `busy` are 1 from the first flag bit through the last delimiter bit, and 0 otherwise.
- R10: When idle, dominant bits with no position marker set, including intermission-coded positions while `in_ifs`=0, start nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bit_tick | input | 1 | One-cycle strobe at each bit sample point |
| rx_bit | input | 1 | Sampled bus level (0 dominant) |
| in_ifs | input | 1 | Current bit lies in the intermission |
| ifs_pos | input | 2 | Index of the current intermission bit |
| eof_last | input | 1 | Current bit is the closing end-of-frame bit |
| err_dlm_last | input | 1 | Current bit is the closing error-delimiter bit |
| is_tx | input | 1 | Node is the transmitter of the current frame |
| msg_stored | input | 1 | Pulse when a received message has been stored |
| req_en | input | 1 | Enable for requested overloads |
| sof_seen | input | 1 | Pulse at the start of a data or remote frame |
| tx_bit | output | 1 | Bit driven onto the bus (0 dominant) |
| busy | output | 1 | Overload frame in progress |
| cnt_hold | output | 1 | Tells the error counters not to count |

## Verification
The assertions check every cycle that:
- a flag bit is never driven without the counter hold;
- an idle block stays recessive;
- outputs move only on a strobe;
- a flag never exceeds six bits;
- an idle dominant bit in the first two intermission positions, or on the error-delimiter close, starts a flag on the next bit.

Some behaviour depends on history across bits, and only the bench scenarios show it. This covers:
- role-dependent handling of the end-of-frame bit;
- arming a request and serving it on the following intermission;
- chaining a second overload off the block's own delimiter;
- the limit of two requested overloads and its reset at start-of-frame.

// File: rtl/can_ovld_pkg.sv
package can_ovld_pkg;
    typedef enum logic [1:0] {
        PH_IDLE  = 2'd0,
        PH_FLAG  = 2'd1,
        PH_DELIM = 2'd2
    } ovld_phase_e;

    localparam int DEF_FLAG_BITS  = 6;
    localparam int DEF_DELIM_BITS = 8;
    localparam int DEF_MAX_REQ    = 2;
    localparam int DEF_REACT_IFS  = 2;
endpackage

// File: rtl/ovld_detect.sv
// Reactive trigger decode: pure combinational view of the current bit.
module ovld_detect #(
    parameter int IFS_POS_W = 2,
    parameter int REACT_IFS = 2
) (
    input  logic                 bit_tick,
    input  logic                 rx_bit,
    input  logic                 idle,
    input  logic                 own_dlm_last,
    input  logic                 in_ifs,
    input  logic [IFS_POS_W-1:0] ifs_pos,
    input  logic                 eof_last,
    input  logic                 err_dlm_last,
    input  logic                 is_tx,
    output logic                 react_hit
);
    localparam logic [IFS_POS_W-1:0] REACT_LIM = IFS_POS_W'(REACT_IFS);

    logic dom;
    logic idle_cond;

    always_comb begin
        dom       = bit_tick && !rx_bit;
        idle_cond = (in_ifs && (ifs_pos < REACT_LIM))   // R2
                  || (eof_last && !is_tx)               // R3
                  || err_dlm_last;                      // R4
        react_hit = dom && ((idle && idle_cond) || own_dlm_last); // R5
    end
endmodule

// File: rtl/ovld_req_track.sv
// Requested-overload bookkeeping: armed flag and per-frame limit.
module ovld_req_track #(
    parameter int MAX_REQ = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic msg_stored,
    input  logic req_en,
    input  logic sof_seen,
    input  logic opp,
    input  logic react_hit,
    output logic req_fire
);
    localparam int RC_W = $clog2(MAX_REQ + 1);
    localparam logic [RC_W-1:0] REQ_LIM = RC_W'(MAX_REQ);

    typedef struct packed {
        logic            pend;
        logic [RC_W-1:0] cnt;
    } req_st_t;

    req_st_t st_d, st_q;
    logic    consume;

    always_comb begin
        st_d     = st_q;
        consume  = opp && !react_hit;
        req_fire = consume && st_q.pend && (st_q.cnt < REQ_LIM);   // R7

        if (consume) begin
            st_d.pend = 1'b0;
        end
        if (req_fire) begin
            st_d.cnt = st_q.cnt + RC_W'(1);
        end
        if (sof_seen) begin
            st_d.pend = 1'b0;
            st_d.cnt  = '0;
        end
        if (msg_stored && req_en) begin                         // R6
            st_d.pend = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end
endmodule

// File: rtl/ovld_seq.sv
// Flag / delimiter sequencer, advancing on bit strobes only.
module ovld_seq
    import can_ovld_pkg::*;
#(
    parameter int FLAG_BITS  = 6,
    parameter int DELIM_BITS = 8
) (
    input  logic clk,
    input  logic rst_n,
    input  logic bit_tick,
    input  logic start,
    output logic idle,
    output logic own_dlm_last,
    output logic tx_bit,
    output logic busy
);
    localparam int MAXB  = (FLAG_BITS > DELIM_BITS) ? FLAG_BITS : DELIM_BITS;
    localparam int CNT_W = $clog2(MAXB + 1);
    localparam logic [CNT_W-1:0] FLAG_END  = CNT_W'(FLAG_BITS - 1);
    localparam logic [CNT_W-1:0] DELIM_END = CNT_W'(DELIM_BITS - 1);

    typedef struct packed {
        ovld_phase_e      ph;
        logic [CNT_W-1:0] cnt;
    } seq_st_t;

    seq_st_t st_d, st_q;

    always_comb begin
        idle         = (st_q.ph == PH_IDLE);
        own_dlm_last = (st_q.ph == PH_DELIM) && (st_q.cnt == DELIM_END);
        tx_bit       = (st_q.ph != PH_FLAG);
        busy         = !idle;
    end

    always_comb begin
        st_d = st_q;
        if (bit_tick) begin
            unique case (st_q.ph)
                PH_IDLE: begin
                    if (start) begin
                        st_d.ph  = PH_FLAG;
                        st_d.cnt = '0;
                    end
                end
                PH_FLAG: begin
                    if (st_q.cnt == FLAG_END) begin
                        st_d.ph  = PH_DELIM;
                        st_d.cnt = '0;
                    end else begin
                        st_d.cnt = st_q.cnt + CNT_W'(1);
                    end
                end
                PH_DELIM: begin
                    if (st_q.cnt == DELIM_END) begin
                        st_d.ph  = start ? PH_FLAG : PH_IDLE;
                        st_d.cnt = '0;
                    end else begin
                        st_d.cnt = st_q.cnt + CNT_W'(1);
                    end
                end
                default: begin
                    st_d.ph  = PH_IDLE;
                    st_d.cnt = '0;
                end
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '{ph: PH_IDLE, cnt: '0};
        end else begin
            st_q <= st_d;
        end
    end
endmodule

// File: rtl/can_ovld_trigger.sv
module can_ovld_trigger
    import can_ovld_pkg::*;
#(
    parameter int FLAG_BITS  = DEF_FLAG_BITS,
    parameter int DELIM_BITS = DEF_DELIM_BITS,
    parameter int MAX_REQ    = DEF_MAX_REQ,
    parameter int REACT_IFS  = DEF_REACT_IFS,
    parameter int IFS_POS_W  = 2
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 bit_tick,
    input  logic                 rx_bit,
    input  logic                 in_ifs,
    input  logic [IFS_POS_W-1:0] ifs_pos,
    input  logic                 eof_last,
    input  logic                 err_dlm_last,
    input  logic                 is_tx,
    input  logic                 msg_stored,
    input  logic                 req_en,
    input  logic                 sof_seen,
    output logic                 tx_bit,
    output logic                 busy,
    output logic                 cnt_hold
);
    logic idle;
    logic own_dlm_last;
    logic react_hit;
    logic req_fire;
    logic opp;
    logic start;

    ovld_detect #(
        .IFS_POS_W (IFS_POS_W),
        .REACT_IFS (REACT_IFS)
    ) u_detect (
        .bit_tick     (bit_tick),
        .rx_bit       (rx_bit),
        .idle         (idle),
        .own_dlm_last (own_dlm_last),
        .in_ifs       (in_ifs),
        .ifs_pos      (ifs_pos),
        .eof_last     (eof_last),
        .err_dlm_last (err_dlm_last),
        .is_tx        (is_tx),
        .react_hit    (react_hit)
    );

    always_comb begin
        // A request is served at the bit that precedes intermission bit 0.
        opp   = bit_tick && ((idle && eof_last) || own_dlm_last);
        start = react_hit || req_fire;
    end

    ovld_req_track #(
        .MAX_REQ (MAX_REQ)
    ) u_req (
        .clk        (clk),
        .rst_n      (rst_n),
        .msg_stored (msg_stored),
        .req_en     (req_en),
        .sof_seen   (sof_seen),
        .opp        (opp),
        .react_hit  (react_hit),
        .req_fire   (req_fire)
    );

    ovld_seq #(
        .FLAG_BITS  (FLAG_BITS),
        .DELIM_BITS (DELIM_BITS)
    ) u_seq (
        .clk          (clk),
        .rst_n        (rst_n),
        .bit_tick     (bit_tick),
        .start        (start),
        .idle         (idle),
        .own_dlm_last (own_dlm_last),
        .tx_bit       (tx_bit),
        .busy         (busy)
    );

    // R9: counters are held for the whole overload frame.
    assign cnt_hold = busy;
endmodule

// File: rtl/can_ovld_trigger_chk.sv
module can_ovld_trigger_chk #(
    parameter int FLAG_BITS = 6,
    parameter int IFS_POS_W = 2
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic                 bit_tick,
    input logic                 rx_bit,
    input logic                 in_ifs,
    input logic [IFS_POS_W-1:0] ifs_pos,
    input logic                 err_dlm_last,
    input logic                 tx_bit,
    input logic                 busy,
    input logic                 cnt_hold
);
    localparam logic [7:0] FLIM = 8'(FLAG_BITS);
    logic [7:0] low_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            low_q <= '0;
        end else if (tx_bit) begin
            low_q <= '0;
        end else if (bit_tick && low_q != 8'hFF) begin
            low_q <= low_q + 8'd1;
        end
    end

    p_hold_on_flag_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !tx_bit |-> cnt_hold);

    p_idle_recessive_r1: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> tx_bit);

    p_move_on_tick_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !bit_tick |=> ($stable(tx_bit) && $stable(busy)));

    p_flag_len_r8: assert property (@(posedge clk) disable iff (!rst_n)
        low_q <= FLIM);

    p_ifs_trigger_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && bit_tick && !rx_bit && in_ifs && ifs_pos < IFS_POS_W'(2))
        |=> (busy && !tx_bit));

    p_err_dlm_trigger_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && bit_tick && !rx_bit && err_dlm_last) |=> (busy && !tx_bit));
endmodule

bind can_ovld_trigger can_ovld_trigger_chk #(
    .FLAG_BITS (FLAG_BITS),
    .IFS_POS_W (IFS_POS_W)
) u_chk (.*);

// File: tb/can_ovld_trigger_test.sv
`timescale 1ns/1ps
module can_ovld_trigger_test;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       bit_tick = 1'b0;
    logic       rx_bit = 1'b1;
    logic       in_ifs = 1'b0;
    logic [1:0] ifs_pos = 2'd0;
    logic       eof_last = 1'b0;
    logic       err_dlm_last = 1'b0;
    logic       is_tx = 1'b0;
    logic       msg_stored = 1'b0;
    logic       req_en = 1'b0;
    logic       sof_seen = 1'b0;
    logic       tx_bit, busy, cnt_hold;

    int checks = 0;
    int errors = 0;

    always #4 clk = ~clk;   // 125 MHz

    can_ovld_trigger uut (
        .clk(clk), .rst_n(rst_n), .bit_tick(bit_tick), .rx_bit(rx_bit),
        .in_ifs(in_ifs), .ifs_pos(ifs_pos), .eof_last(eof_last),
        .err_dlm_last(err_dlm_last), .is_tx(is_tx), .msg_stored(msg_stored),
        .req_en(req_en), .sof_seen(sof_seen), .tx_bit(tx_bit), .busy(busy),
        .cnt_hold(cnt_hold)
    );

    task automatic chk(input logic act, input logic exp, input string req, input string what);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: actual %b expected %b", req, what, act, exp);
        end
    endtask

    // One bit time: strobe with the given markers, then three quiet cycles.
    task automatic send_bit(input logic rx, input logic ifs, input logic [1:0] pos,
                            input logic eof, input logic dlm, input logic sof);
        @(negedge clk);
        rx_bit = rx; in_ifs = ifs; ifs_pos = pos;
        eof_last = eof; err_dlm_last = dlm; sof_seen = sof; bit_tick = 1'b1;
        @(negedge clk);
        bit_tick = 1'b0; in_ifs = 1'b0; ifs_pos = 2'd0;
        eof_last = 1'b0; err_dlm_last = 1'b0; sof_seen = 1'b0; rx_bit = 1'b1;
        repeat (2) @(negedge clk);
    endtask

    task automatic plain_bit(input logic rx);
        send_bit(rx, 1'b0, 2'd0, 1'b0, 1'b0, 1'b0);
    endtask

    task automatic pulse_msg();
        @(negedge clk); msg_stored = 1'b1;
        @(negedge clk); msg_stored = 1'b0;
    endtask

    task automatic expect_started(input string req);
        chk(tx_bit, 1'b0, req, "flag starts on next bit");
        chk(busy, 1'b1, req, "busy at flag start");
    endtask

    task automatic expect_idle(input string req);
        chk(busy, 1'b0, req, "no overload");
        chk(tx_bit, 1'b1, req, "recessive when idle");
    endtask

    // Checks a flag already in progress and walks through the delimiter,
    // leaving the block on the last delimiter bit.
    task automatic walk_frame(input string req);
        for (int i = 0; i < 6; i++) begin
            chk(tx_bit, 1'b0, "R8", $sformatf("%s flag bit %0d dominant", req, i));
            chk(cnt_hold, 1'b1, "R9", "hold during flag");
            plain_bit(1'b0);
        end
        for (int i = 0; i < 7; i++) begin
            chk(tx_bit, 1'b1, "R8", $sformatf("%s delim bit %0d recessive", req, i));
            chk(cnt_hold, 1'b1, "R9", "hold during delimiter");
            plain_bit(1'b1);
        end
        chk(tx_bit, 1'b1, "R8", "last delimiter bit recessive");
        chk(busy, 1'b1, "R9", "busy on last delimiter bit");
    endtask

    task automatic finish_frame_quiet(input string req);
        walk_frame(req);
        plain_bit(1'b1);
        chk(busy, 1'b0, "R9", "idle after 8 delimiter bits");
        chk(cnt_hold, 1'b0, "R9", "hold released");
    endtask

    task automatic t_reset();
        chk(tx_bit, 1'b1, "R1", "tx after reset");
        chk(busy, 1'b0, "R1", "busy after reset");
        chk(cnt_hold, 1'b0, "R1", "hold after reset");
    endtask

    task automatic t_ifs();
        send_bit(1'b0, 1'b1, 2'd0, 1'b0, 1'b0, 1'b0);
        expect_started("R2");
        finish_frame_quiet("R2 ifs0");
        send_bit(1'b0, 1'b1, 2'd1, 1'b0, 1'b0, 1'b0);
        expect_started("R2");
        finish_frame_quiet("R2 ifs1");
        send_bit(1'b0, 1'b1, 2'd2, 1'b0, 1'b0, 1'b0);
        expect_idle("R2");
    endtask

    task automatic t_eof();
        is_tx = 1'b0;
        send_bit(1'b0, 1'b0, 2'd0, 1'b1, 1'b0, 1'b0);
        expect_started("R3");
        finish_frame_quiet("R3");
        is_tx = 1'b1;
        send_bit(1'b0, 1'b0, 2'd0, 1'b1, 1'b0, 1'b0);
        expect_idle("R3");
        is_tx = 1'b0;
    endtask

    task automatic t_err_dlm();
        is_tx = 1'b1;
        send_bit(1'b0, 1'b0, 2'd0, 1'b0, 1'b1, 1'b0);
        expect_started("R4");
        finish_frame_quiet("R4");
        send_bit(1'b1, 1'b0, 2'd0, 1'b0, 1'b1, 1'b0);
        expect_idle("R4");
        is_tx = 1'b0;
    endtask

    task automatic t_own_dlm();
        send_bit(1'b0, 1'b1, 2'd0, 1'b0, 1'b0, 1'b0);
        walk_frame("R5");
        plain_bit(1'b0);
        expect_started("R5");
        finish_frame_quiet("R5 second");
    endtask

    task automatic t_request();
        req_en = 1'b0;
        pulse_msg();
        send_bit(1'b1, 1'b0, 2'd0, 1'b1, 1'b0, 1'b0);
        expect_idle("R6");
        plain_bit(1'b1);
        expect_idle("R6");
        req_en = 1'b1;
        send_bit(1'b0, 1'b0, 2'd0, 1'b0, 1'b0, 1'b1);
        pulse_msg();
        send_bit(1'b1, 1'b0, 2'd0, 1'b1, 1'b0, 1'b0);
        expect_started("R6");
        finish_frame_quiet("R6");
    endtask

    task automatic t_limit();
        req_en = 1'b1;
        send_bit(1'b0, 1'b0, 2'd0, 1'b0, 1'b0, 1'b1);
        pulse_msg();
        send_bit(1'b1, 1'b0, 2'd0, 1'b1, 1'b0, 1'b0);
        expect_started("R7");
        walk_frame("R7 first");
        pulse_msg();
        plain_bit(1'b1);
        expect_started("R7");
        walk_frame("R7 second");
        pulse_msg();
        plain_bit(1'b1);
        chk(busy, 1'b0, "R7", "third request dropped");
        send_bit(1'b0, 1'b0, 2'd0, 1'b0, 1'b0, 1'b1);
        expect_idle("R7");
        pulse_msg();
        send_bit(1'b1, 1'b0, 2'd0, 1'b1, 1'b0, 1'b0);
        expect_started("R7");
        finish_frame_quiet("R7 after sof");
        req_en = 1'b0;
    endtask

    task automatic t_ignored();
        plain_bit(1'b0);
        expect_idle("R10");
        send_bit(1'b0, 1'b0, 2'd1, 1'b0, 1'b0, 1'b0);
        expect_idle("R10");
        send_bit(1'b0, 1'b0, 2'd0, 1'b0, 1'b0, 1'b1);
        expect_idle("R10");
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_ifs();
        t_eof();
        t_err_dlm();
        t_own_dlm();
        t_request();
        t_limit();
        t_ignored();
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule